// File: doc/BRIEF.md
# Total-Store-Order Store Buffer with Load Forwarding

This block sits between a core's memory pipeline and a coherent data cache. Stores from the core are taken into a small in-order queue in the cycle they are offered, so the core runs on while the cache is still busy. The queue hands its oldest entry to the cache write port, and an entry leaves only when the cache says it can take it. Nothing else can make the queue empty sooner.

Loads are served in the cycle they are offered. A load first searches the queue, and the store being accepted in the same cycle, for entries with the same address. When there is a match, the data comes from the youngest matching store and the cache is not asked. When there is no match, the load goes to the cache read port at once, ahead of any older queued stores to other addresses. The only reordering this allows is a later load passing an earlier store, which is the total-store-order rule.

A barrier request that orders stores against later loads (the store-to-load kind, or a full fence) holds off every later load until the queue has drained on its own. Barrier kinds that only order load-load, load-store or store-store pairs change nothing, because the queue never reorders those pairs.

Top module: `stq_store_buffer`

## Requirements
- R1: After a synchronous reset with `rst_n` low, the outputs show `empty`=1, `st_ready`=1, `cw_valid`=0 and `fence_busy`=0.
- R2: While fewer than DEPTH entries are held, `st_ready` is 1 and a store offered with `st_valid` is taken in that same cycle, whatever `cw_ready` is doing.
- R3: With DEPTH entries held, `st_ready` is 0 and an offered store is not taken. It is not written to the cache later either.
- R4: `cw_valid` is 1 exactly when the buffer is not empty. `cw_addr`/`cw_data` show the oldest entry, and entries reach the cache in the order they were accepted. An entry is removed only in a cycle with `cw_valid` and `cw_ready` both 1.
- R5: While `cw_ready` is 0, the head entry stays on `cw_addr`/`cw_data` unchanged, even when a fence is pending. No input drains the buffer without `cw_ready`.
- R6: A load served while the buffer holds stores to its address gives `ld_fwd`=1 and returns the data of the youngest such store in `ld_data`. In that cycle `cr_req` is 0.
- R7: A store accepted in the same cycle as a load to the same address counts as the youngest match for that load.
- R8: A load with no matching entry raises `cr_req` with `cr_addr` equal to `ld_addr`, gives `ld_fwd`=0 and returns `cr_data` in the same cycle, even while older stores to other addresses are still queued.
- R9: A fence request with `fence_kind` 3'b011 (store-to-load) or 3'b100 (full), made while the buffer is not empty, raises `fence_busy` in that cycle. `fence_busy` stays high until the first cycle in which the buffer is empty, and `ld_ready` is 0 while it is high. The same request made while the buffer is empty has no effect.
- R10: A fence request with `fence_kind` 3'b000, 3'b001, 3'b010 or 3'b101 to 3'b111 leaves `fence_busy` and `ld_ready` unchanged.
- R11: A reset while a fence is pending clears `fence_busy` and empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Buffer can take a store this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core offers a load |
| ld_ready | output | 1 | Load is served this cycle (low while a fence waits) |
| ld_addr | input | AW | Load address |
| ld_fwd | output | 1 | Served load took its data from the buffer |
| ld_data | output | DW | Load result |
| cr_req | output | 1 | Cache read request for a load that missed the buffer |
| cr_addr | output | AW | Cache read address |
| cr_data | input | DW | Cache read data, same cycle |
| cw_valid | output | 1 | Oldest entry offered to the cache |
| cw_ready | input | 1 | Cache takes the offered entry |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |
| fence_req | input | 1 | Barrier request |
| fence_kind | input | 3 | Barrier kind: 000 load-load, 001 load-store, 010 store-store, 011 store-to-load, 100 full |
| fence_busy | output | 1 | A store-to-load ordering barrier is waiting for the drain |
| empty | output | 1 | Buffer holds no entries |

## Verification
The hardest state to reach is a buffer that is full of repeated addresses with the cache refusing writes while an ordering fence waits. Only in that state do youngest-match selection, the head entry held in place and the load stall all act together. The stimulus builds it directly: it holds `cw_ready` low, fills every slot with stores that alternate between two addresses, offers one store too many, and then raises a store-to-load fence with loads pending for twenty cycles before the cache is let go. A random phase over eight addresses, with `cw_ready` mostly low, then reaches same-cycle store and load matches and wrap-around of the ring pointers many times over.

// File: rtl/stq_pkg.sv
package stq_pkg;

   typedef enum logic [2:0] {
      BAR_LD_LD = 3'b000,
      BAR_LD_ST = 3'b001,
      BAR_ST_ST = 3'b010,
      BAR_ST_LD = 3'b011,
      BAR_FULL  = 3'b100
   } barrier_e;

   // Only barriers that keep later loads behind earlier stores act here.
   function automatic logic orders_store_load(input logic [2:0] kind);
      return (kind == BAR_ST_LD) || (kind == BAR_FULL);
   endfunction

endpackage

// File: rtl/stq_ring.sv
module stq_ring #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [PW-1:0] rd_ptr,
   output logic [PW:0]   count,
   output logic [PW:0]   count_nxt,
   output logic [AW-1:0] ent_addr [DEPTH],
   output logic [DW-1:0] ent_data [DEPTH]
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [PW-1:0] wr_ptr;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + PW'(1);
   endfunction

   assign count_nxt = count + (PW+1)'(push) - (PW+1)'(pop);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= bump(wr_ptr);
         if (pop)  rd_ptr <= bump(rd_ptr);
         count <= count_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         ent_addr[wr_ptr] <= push_addr;
         ent_data[wr_ptr] <= push_data;
      end
   end

endmodule

// File: rtl/stq_fwd_match.sv
module stq_fwd_match #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic [PW-1:0] rd_ptr,
   input  logic [PW:0]   count,
   input  logic [AW-1:0] ent_addr [DEPTH],
   input  logic [DW-1:0] ent_data [DEPTH],
   input  logic          new_valid,
   input  logic [AW-1:0] new_addr,
   input  logic [DW-1:0] new_data,
   input  logic [AW-1:0] ld_addr,
   output logic          hit,
   output logic [DW-1:0] hit_data
);

   localparam logic [PW:0] DEP = (PW+1)'(DEPTH);

   logic [DEPTH-1:0] match;

   // One comparator per slot; a slot is live if its age offset is below count.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      localparam logic [PW:0] GI = (PW+1)'(g);
      logic [PW:0] age;
      assign age = (GI >= {1'b0, rd_ptr}) ? GI - {1'b0, rd_ptr}
                                          : GI + DEP - {1'b0, rd_ptr};
      assign match[g] = (age < count) && (ent_addr[g] == ld_addr);
   end

   // Walk from oldest to youngest so the last match seen wins.
   always_comb begin
      logic [PW:0] sum_v;
      logic [PW:0] idx_v;
      hit      = 1'b0;
      hit_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         sum_v = {1'b0, rd_ptr} + (PW+1)'(k);
         idx_v = (sum_v >= DEP) ? sum_v - DEP : sum_v;
         if (match[idx_v[PW-1:0]]) begin
            hit      = 1'b1;
            hit_data = ent_data[idx_v[PW-1:0]];
         end
      end
      if (new_valid && (new_addr == ld_addr)) begin
         hit      = 1'b1;
         hit_data = new_data;
      end
   end

endmodule

// File: rtl/stq_fence_ctl.sv
module stq_fence_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fence_req,
   input  logic [2:0] fence_kind,
   input  logic       buf_empty,
   input  logic       empty_nxt,
   output logic       busy
);
   import stq_pkg::*;

   logic eff;
   logic pend_q;

   assign eff  = fence_req && orders_store_load(fence_kind);
   assign busy = pend_q || (eff && !buf_empty);

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q || eff) && !empty_nxt;
   end

endmodule

// File: rtl/stq_store_buffer.sv
module stq_store_buffer #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic          ld_valid,
   output logic          ld_ready,
   input  logic [AW-1:0] ld_addr,
   output logic          ld_fwd,
   output logic [DW-1:0] ld_data,
   output logic          cr_req,
   output logic [AW-1:0] cr_addr,
   input  logic [DW-1:0] cr_data,
   output logic          cw_valid,
   input  logic          cw_ready,
   output logic [AW-1:0] cw_addr,
   output logic [DW-1:0] cw_data,
   input  logic          fence_req,
   input  logic [2:0]    fence_kind,
   output logic          fence_busy,
   output logic          empty
);

   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("stq_store_buffer: DEPTH must be at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("stq_store_buffer: AW and DW must be positive");
   end

   logic          push, pop, hit;
   logic [PW-1:0] rd_ptr;
   logic [PW:0]   count, count_nxt;
   logic [AW-1:0] ent_addr [DEPTH];
   logic [DW-1:0] ent_data [DEPTH];
   logic [DW-1:0] hit_data;
   logic          served;

   assign empty    = (count == '0);
   assign st_ready = (count != (PW+1)'(DEPTH));
   assign push     = st_valid && st_ready;
   assign cw_valid = !empty;
   assign pop      = cw_valid && cw_ready;
   assign cw_addr  = ent_addr[rd_ptr];
   assign cw_data  = ent_data[rd_ptr];

   stq_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .rd_ptr    (rd_ptr),
      .count     (count),
      .count_nxt (count_nxt),
      .ent_addr  (ent_addr),
      .ent_data  (ent_data)
   );

   stq_fwd_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_match (
      .rd_ptr    (rd_ptr),
      .count     (count),
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .new_valid (push),
      .new_addr  (st_addr),
      .new_data  (st_data),
      .ld_addr   (ld_addr),
      .hit       (hit),
      .hit_data  (hit_data)
   );

   stq_fence_ctl i_fence (
      .clk        (clk),
      .rst_n      (rst_n),
      .fence_req  (fence_req),
      .fence_kind (fence_kind),
      .buf_empty  (empty),
      .empty_nxt  (count_nxt == '0),
      .busy       (fence_busy)
   );

   assign ld_ready = !fence_busy;
   assign served   = ld_valid && ld_ready;
   assign ld_fwd   = served && hit;
   assign cr_req   = served && !hit;
   assign cr_addr  = ld_addr;
   assign ld_data  = hit ? hit_data : cr_data;

endmodule

// File: rtl/stq_store_buffer_checker.sv
module stq_store_buffer_checker #(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_ready,
   input logic          ld_valid,
   input logic          ld_ready,
   input logic          ld_fwd,
   input logic [AW-1:0] ld_addr,
   input logic          cr_req,
   input logic [AW-1:0] cr_addr,
   input logic          cw_valid,
   input logic          cw_ready,
   input logic [AW-1:0] cw_addr,
   input logic [DW-1:0] cw_data,
   input logic          fence_busy,
   input logic          empty
);

   // R3: a full buffer that writes nothing to the cache stays full
   p_full_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_ready && !(cw_valid && cw_ready)) |=> !st_ready);

   // R5: the head entry is held while the cache refuses it
   p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_addr) && $stable(cw_data)));

   // R6: a forwarded load never reaches the cache
   p_fwd_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fwd |-> (!cr_req && ld_valid));

   // R8: an unforwarded served load reads the cache at its own address
   p_miss_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_ready && !ld_fwd) |-> (cr_req && cr_addr == ld_addr));

   // R9: loads stall while the fence waits
   p_fence_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fence_busy |-> !ld_ready);

   // R9: a waiting fence implies stores still queued
   p_busy_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fence_busy |-> !empty);

   // R9: the fence ends only once the buffer has drained
   p_release_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fence_busy) |-> empty);

endmodule

bind stq_store_buffer stq_store_buffer_checker #(.AW(AW), .DW(DW)) i_stq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .st_ready   (st_ready),
   .ld_valid   (ld_valid),
   .ld_ready   (ld_ready),
   .ld_fwd     (ld_fwd),
   .ld_addr    (ld_addr),
   .cr_req     (cr_req),
   .cr_addr    (cr_addr),
   .cw_valid   (cw_valid),
   .cw_ready   (cw_ready),
   .cw_addr    (cw_addr),
   .cw_data    (cw_data),
   .fence_busy (fence_busy),
   .empty      (empty)
);

// File: tb/test_stq_store_buffer.sv
`timescale 1ns/1ps
module test_stq_store_buffer;

   localparam int DEPTH = 8;
   localparam int AW    = 16;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0, ld_valid = 1'b0, cw_ready = 1'b0, fence_req = 1'b0;
   logic [AW-1:0] st_addr = '0, ld_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic [2:0]    fence_kind = 3'b000;
   logic          st_ready, ld_ready, ld_fwd, cr_req, cw_valid, fence_busy, empty;
   logic [AW-1:0] cr_addr, cw_addr;
   logic [DW-1:0] ld_data, cr_data, cw_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [AW-1:0] m_addr [$];
   logic [DW-1:0] m_data [$];
   bit            m_pend = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
      return {a, ~a} ^ 32'h5A5A_0F0F;
   endfunction

   assign cr_data = mem_fn(cr_addr);

   stq_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_stq_store_buffer (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_fwd(ld_fwd),
      .ld_data(ld_data), .cr_req(cr_req), .cr_addr(cr_addr), .cr_data(cr_data),
      .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_addr(cw_addr), .cw_data(cw_data),
      .fence_req(fence_req), .fence_kind(fence_kind), .fence_busy(fence_busy), .empty(empty)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit eff_kind(input logic [2:0] k);
      return (k == 3'b011) || (k == 3'b100);
   endfunction

   // Called just after a falling edge with inputs set; checks, then advances one cycle.
   task automatic step();
      bit full = 0, emp = 0, busy = 0, eff = 0, acc = 0, pop = 0, hit = 0, hitnew = 0;
      logic [DW-1:0] hd = '0;
      string tag;
      #2;
      if (rst_n) begin
         full = (m_addr.size() == DEPTH);
         emp  = (m_addr.size() == 0);
         eff  = fence_req && eff_kind(fence_kind);
         busy = m_pend || (eff && !emp);
         acc  = st_valid && !full;
         pop  = !emp && cw_ready;
         chk(full ? "R3" : "R2", 64'(st_ready), 64'(!full));
         chk("R4", 64'(empty), 64'(emp));
         chk("R4", 64'(cw_valid), 64'(!emp));
         if (!emp) begin
            tag = cw_ready ? "R4" : "R5";
            chk(tag, 64'(cw_addr), 64'(m_addr[0]));
            chk(tag, 64'(cw_data), 64'(m_data[0]));
         end
         tag = (fence_req && !eff) ? "R10" : "R9";
         chk(tag, 64'(fence_busy), 64'(busy));
         chk(tag, 64'(ld_ready), 64'(!busy));
         if (ld_valid && !busy) begin
            foreach (m_addr[i]) if (m_addr[i] == ld_addr) begin hit = 1; hd = m_data[i]; end
            if (acc && st_addr == ld_addr) begin hit = 1; hitnew = 1; hd = st_data; end
            tag = hitnew ? "R7" : (hit ? "R6" : "R8");
            chk(tag, 64'(ld_fwd), 64'(hit));
            chk(tag, 64'(ld_data), 64'(hit ? hd : mem_fn(ld_addr)));
            chk("R8", 64'(cr_req), 64'(!hit));
         end
      end
      @(posedge clk);
      #1;
      if (!rst_n) begin
         m_addr.delete(); m_data.delete(); m_pend = 0;
      end else begin
         if (pop) begin void'(m_addr.pop_front()); void'(m_data.pop_front()); end
         if (acc) begin m_addr.push_back(st_addr); m_data.push_back(st_data); end
         m_pend = (m_pend || eff) && (m_addr.size() > 0);
      end
      @(negedge clk);
   endtask

   task automatic idle();
      st_valid = 0; ld_valid = 0; fence_req = 0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      rst_n = 0;
      repeat (3) step();
      rst_n = 1;
      #2;
      chk("R1", 64'(empty), 64'd1);
      chk("R1", 64'(st_ready), 64'd1);
      chk("R1", 64'(cw_valid), 64'd0);
      chk("R1", 64'(fence_busy), 64'd0);
      @(negedge clk);

      // Fill with alternating addresses while the cache refuses writes
      cw_ready = 0;
      for (int i = 0; i < DEPTH; i++) begin
         st_valid = 1; st_addr = (i % 2) ? 16'h5 : 16'h3; st_data = 32'h100 + i;
         step();
      end
      // Overflow attempt with a load to the repeated address (youngest wins)
      st_valid = 1; st_addr = 16'h3; st_data = 32'hDEAD;
      ld_valid = 1; ld_addr = 16'h3;
      step();
      st_valid = 0; ld_addr = 16'h9;
      step();
      // No-op barrier kinds
      for (int k = 0; k < 3; k++) begin
         fence_req = 1; fence_kind = 3'(k); ld_addr = 16'h5;
         step();
      end
      fence_req = 1; fence_kind = 3'b111;
      step();
      // Store-to-load fence while full and blocked
      fence_kind = 3'b011;
      step();
      fence_req = 0; ld_addr = 16'h3;
      repeat (20) step();
      chk("R5", 64'(cw_data), 64'h100);
      cw_ready = 1;
      repeat (DEPTH + 2) step();
      chk("R9", 64'(fence_busy), 64'd0);
      // Same-cycle store and load
      st_valid = 1; st_addr = 16'h7; st_data = 32'hCAFE; ld_addr = 16'h7;
      step();
      idle();
      step();
      // Fence with an empty buffer
      fence_req = 1; fence_kind = 3'b100;
      step();
      // Reset while a fence waits
      idle(); cw_ready = 0;
      for (int i = 0; i < 3; i++) begin
         st_valid = 1; st_addr = 16'(i); st_data = 32'(i);
         step();
      end
      st_valid = 0; fence_req = 1; fence_kind = 3'b100;
      step();
      fence_req = 0;
      rst_n = 0;
      step();
      rst_n = 1;
      #2;
      chk("R11", 64'(empty), 64'd1);
      chk("R11", 64'(fence_busy), 64'd0);
      @(negedge clk);

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         st_valid   = ($urandom % 2) == 0;
         st_addr    = 16'($urandom % 8);
         st_data    = $urandom;
         ld_valid   = ($urandom % 2) == 0;
         ld_addr    = 16'($urandom % 8);
         cw_ready   = ((n % 400) > 340) ? 1'b1 : (($urandom % 10) < 3);
         fence_req  = ($urandom % 20) == 0;
         fence_kind = 3'($urandom % 8);
         step();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule